// File: doc/BRIEF.md
# Trace-segment micro-operation sequencer

This block feeds decoded micro-operations to an execution-side consumer from a small direct-mapped trace store. A fetch request names a start address. If the store already holds a valid segment for that address, the block replays it. If not, the block treats the request as a trace miss. It waits out a fixed refill delay, then accepts translated micro-operations on a fill port, assembles them into a new segment, writes the segment into the store and replays it.

A stored entry is either a plain micro-operation or an escape marker. A marker carries a pointer into an internal microcode table. When replay reaches a marker, the output source switches to that table and streams words until one flagged as the end of its sequence. Replay then resumes with the trace entry that follows the marker. The output is a ready/valid stream. Consecutive entries, including branch targets laid into the segment, come out back to back. A stall from the consumer only holds the current word.

Top module: `tseq_top`

## Requirements
- R1: While and right after `rst` is high, `out_valid`, `fill_ready` and `building` are 0, `req_ready` is 1, and every stored segment is invalid, so the first request after reset misses.
- R2: A request accepted in idle (`req_valid` and `req_ready`) hits when the segment at index `req_addr[3:0]` is valid and its stored tag equals `req_addr[11:4]`. On a hit, `building` stays 0 and `out_valid` is 1 in the very next cycle.
- R3: Any other accepted request is a miss. `building` goes to 1 in the next cycle, and `fill_ready` stays 0 for exactly 8 cycles before it rises.
- R4: In build mode, each cycle with `fill_valid` and `fill_ready` stores one entry (a marker when `fill_is_tag` is 1). The segment closes on an entry with `fill_last` set, or on its 6th entry. In the cycle after the close, `fill_ready` and `building` are 0 and replay of the new segment has begun (`out_valid` is 1).
- R5: Replay emits the entries in fill order. `out_seg_end` is 1 on the final word of the segment. In the cycle after that word is taken, `out_valid` is 0 and `req_ready` is 1.
- R6: A marker entry is replaced in the output by table words. The first word is at pointer `fill_data[4:0]`, and each following word is at the next address. The word at address a has value 0xE000 | a, and `out_from_rom` is 1 while it is shown. The sequence ends after the word whose address has low two bits 11, and output continues with the entry that follows the marker. A marker may be the first or the last entry.
- R7: With `out_ready` held at 1, `out_valid` is 1 in every cycle from the first to the last word of a segment, across marker boundaries, with no bubble.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and `out_uop` and `out_from_rom` unchanged. No word is lost or repeated.
- R9: The store is direct-mapped. Building a segment at an index replaces the segment held there, and a later request to the replaced address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request strobe |
| req_addr | input | 12 | Segment start address |
| req_ready | output | 1 | Block is idle and takes a request |
| fill_valid | input | 1 | Fill entry present |
| fill_is_tag | input | 1 | Fill entry is an escape marker |
| fill_data | input | 16 | Micro-operation, or table pointer in bits 4:0 for a marker |
| fill_last | input | 1 | Final entry of the segment being built |
| fill_ready | output | 1 | Fill entry accepted this cycle |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_uop | output | 16 | Output micro-operation |
| out_from_rom | output | 1 | Word comes from the microcode table |
| out_seg_end | output | 1 | Word is the last of the segment |
| building | output | 1 | Block is in miss delay or build mode |

## Verification
The bench uses the default parameters: a 12-bit address split into a 4-bit index and an 8-bit tag, 6 entries per segment, a 32-word table in 4-word blocks, and an 8-cycle miss delay. These small sizes let a handful of addresses reach the important cases. Two addresses alias on one index, which forces an eviction. One segment fills all 6 slots without a last flag. Table sequences of one, two, three and four words occur with the marker as the first, a middle and the final entry. A repeating consumer stall pattern exercises the hold and no-repeat behaviour during both trace and table output.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
    parameter int ADDR_W      = 12;
    parameter int IDX_W       = 4;
    parameter int SEGS        = 1 << IDX_W;
    parameter int TAG_W       = ADDR_W - IDX_W;
    parameter int UOP_W       = 16;
    parameter int ENTRIES     = 6;
    parameter int PTR_W       = $clog2(ENTRIES);
    parameter int ROM_DEPTH   = 32;
    parameter int ROM_AW      = $clog2(ROM_DEPTH);
    parameter int ROM_BLOCK   = 4;
    parameter int MISS_CYCLES = 8;
    parameter int MISS_W      = $clog2(MISS_CYCLES + 1);

    typedef struct packed {
        logic             valid;
        logic             is_tag;
        logic [UOP_W-1:0] payload;
    } entry_t;

    typedef entry_t [ENTRIES-1:0] segment_t;

    typedef struct packed {
        logic             eos;
        logic [UOP_W-1:0] uop;
    } rom_word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MISS,
        ST_BUILD,
        ST_PLAY
    } state_t;

    function automatic rom_word_t rom_content(input int unsigned a);
        rom_word_t w;
        w.uop = {4'hE, (UOP_W-4)'(a)};
        w.eos = ((a % ROM_BLOCK) == (ROM_BLOCK - 1));
        return w;
    endfunction

    function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
        return a[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/tseq_store.sv
module tseq_store
    import tseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [PTR_W-1:0] rd_ptr,
    output entry_t           rd_entry,
    output logic             rd_more,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  segment_t         wr_seg
);
    entry_t           mem     [SEGS][ENTRIES];
    logic [TAG_W-1:0] seg_tag [SEGS];
    logic [SEGS-1:0]  seg_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_ok <= '0;
        end else if (wr_en) begin
            seg_ok[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            seg_tag[wr_idx] <= wr_tag;
            for (int e = 0; e < ENTRIES; e++) begin
                mem[wr_idx][e] <= wr_seg[e];
            end
        end
    end

    assign lk_hit   = seg_ok[lk_idx] && (seg_tag[lk_idx] == lk_tag) && mem[lk_idx][0].valid;
    assign rd_entry = mem[rd_idx][rd_ptr];

    always_comb begin
        if (rd_ptr == PTR_W'(ENTRIES - 1)) begin
            rd_more = 1'b0;
        end else begin
            rd_more = mem[rd_idx][rd_ptr + PTR_W'(1)].valid;
        end
    end
endmodule

// File: rtl/tseq_rom.sv
module tseq_rom
    import tseq_pkg::*;
(
    input  logic [ROM_AW-1:0] rom_addr,
    output rom_word_t         rom_word
);
    rom_word_t tbl [ROM_DEPTH];

    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_word
        assign tbl[g] = rom_content(g);
    end

    assign rom_word = tbl[rom_addr];
endmodule

// File: rtl/tseq_ctrl.sv
module tseq_ctrl
    import tseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              lk_hit,
    input  logic              fill_valid,
    input  logic              fill_is_tag,
    input  logic [UOP_W-1:0]  fill_data,
    input  logic              fill_last,
    output logic              fill_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [UOP_W-1:0]  out_uop,
    output logic              out_from_rom,
    output logic              out_seg_end,
    output logic              building,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [PTR_W-1:0]  rd_ptr,
    input  entry_t            rd_entry,
    input  logic              rd_more,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output segment_t          wr_seg,
    output logic [ROM_AW-1:0] rom_addr,
    input  rom_word_t         rom_word
);
    state_t            st;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic [MISS_W-1:0] wait_q;
    logic [PTR_W-1:0]  bcnt_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [ROM_AW-1:0] roff_q;
    entry_t            bufq [ENTRIES];

    entry_t fill_ent;
    logic   playing;
    logic   fill_fire;
    logic   close_seg;
    logic   cur_tag;
    logic   done_ent;
    logic   last_ent;

    assign fill_ent.valid   = 1'b1;
    assign fill_ent.is_tag  = fill_is_tag;
    assign fill_ent.payload = fill_data;

    assign playing    = (st == ST_PLAY);
    assign req_ready  = (st == ST_IDLE);
    assign fill_ready = (st == ST_BUILD);
    assign building   = (st == ST_MISS) || (st == ST_BUILD);
    assign fill_fire  = fill_ready && fill_valid;
    assign close_seg  = fill_fire && (fill_last || (bcnt_q == PTR_W'(ENTRIES - 1)));

    assign rd_idx = idx_q;
    assign rd_ptr = ptr_q;
    assign wr_idx = idx_q;
    assign wr_tag = tag_q;
    assign wr_en  = close_seg;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (PTR_W'(i) < bcnt_q) begin
                wr_seg[i] = bufq[i];
            end else if (PTR_W'(i) == bcnt_q) begin
                wr_seg[i] = fill_ent;
            end else begin
                wr_seg[i] = '0;
            end
        end
    end

    assign cur_tag      = rd_entry.is_tag;
    assign rom_addr     = rd_entry.payload[ROM_AW-1:0] + roff_q;
    assign out_valid    = playing;
    assign out_uop      = cur_tag ? rom_word.uop : rd_entry.payload;
    assign out_from_rom = playing && cur_tag;
    assign done_ent     = !cur_tag || rom_word.eos;
    assign last_ent     = !rd_more;
    assign out_seg_end  = playing && done_ent && last_ent;

    always_ff @(posedge clk) begin
        if (fill_fire) begin
            bufq[bcnt_q] <= fill_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            idx_q  <= '0;
            tag_q  <= '0;
            wait_q <= '0;
            bcnt_q <= '0;
            ptr_q  <= '0;
            roff_q <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        idx_q  <= addr_index(req_addr);
                        tag_q  <= addr_tag(req_addr);
                        wait_q <= '0;
                        bcnt_q <= '0;
                        ptr_q  <= '0;
                        roff_q <= '0;
                        st     <= lk_hit ? ST_PLAY : ST_MISS;
                    end
                end
                ST_MISS: begin
                    if (wait_q == MISS_W'(MISS_CYCLES - 1)) begin
                        st <= ST_BUILD;
                    end else begin
                        wait_q <= wait_q + MISS_W'(1);
                    end
                end
                ST_BUILD: begin
                    if (close_seg) begin
                        st <= ST_PLAY;
                    end else if (fill_fire) begin
                        bcnt_q <= bcnt_q + PTR_W'(1);
                    end
                end
                ST_PLAY: begin
                    if (out_ready) begin
                        if (!done_ent) begin
                            roff_q <= roff_q + ROM_AW'(1);
                        end else begin
                            roff_q <= '0;
                            if (last_ent) begin
                                st <= ST_IDLE;
                            end else begin
                                ptr_q <= ptr_q + PTR_W'(1);
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tseq_top.sv
module tseq_top
    import tseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              fill_valid,
    input  logic              fill_is_tag,
    input  logic [UOP_W-1:0]  fill_data,
    input  logic              fill_last,
    output logic              fill_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [UOP_W-1:0]  out_uop,
    output logic              out_from_rom,
    output logic              out_seg_end,
    output logic              building
);
    logic              lk_hit;
    logic [IDX_W-1:0]  rd_idx;
    logic [PTR_W-1:0]  rd_ptr;
    entry_t            rd_entry;
    logic              rd_more;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    segment_t          wr_seg;
    logic [ROM_AW-1:0] rom_addr;
    rom_word_t         rom_word;

    tseq_store u_store (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (addr_index(req_addr)),
        .lk_tag   (addr_tag(req_addr)),
        .lk_hit   (lk_hit),
        .rd_idx   (rd_idx),
        .rd_ptr   (rd_ptr),
        .rd_entry (rd_entry),
        .rd_more  (rd_more),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_seg   (wr_seg)
    );

    tseq_rom u_rom (
        .rom_addr (rom_addr),
        .rom_word (rom_word)
    );

    tseq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_ready    (req_ready),
        .lk_hit       (lk_hit),
        .fill_valid   (fill_valid),
        .fill_is_tag  (fill_is_tag),
        .fill_data    (fill_data),
        .fill_last    (fill_last),
        .fill_ready   (fill_ready),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_uop      (out_uop),
        .out_from_rom (out_from_rom),
        .out_seg_end  (out_seg_end),
        .building     (building),
        .rd_idx       (rd_idx),
        .rd_ptr       (rd_ptr),
        .rd_entry     (rd_entry),
        .rd_more      (rd_more),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_tag       (wr_tag),
        .wr_seg       (wr_seg),
        .rom_addr     (rom_addr),
        .rom_word     (rom_word)
    );
endmodule

// File: rtl/tseq_checker.sv
module tseq_checker
    import tseq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             fill_valid,
    input logic             fill_ready,
    input logic             fill_last,
    input logic             out_valid,
    input logic             out_ready,
    input logic [UOP_W-1:0] out_uop,
    input logic             out_from_rom,
    input logic             out_seg_end,
    input logic             building
);
    logic [MISS_W:0] wait_c;

    always_ff @(posedge clk) begin
        if (rst || !building) begin
            wait_c <= '0;
        end else if (wait_c < (MISS_W+1)'(MISS_CYCLES)) begin
            wait_c <= wait_c + (MISS_W+1)'(1);
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && req_ready && !fill_ready && !building));

    assert_play_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> ($past(req_valid && req_ready) || $past(fill_valid && fill_ready)));

    assert_miss_delay_R3: assert property (@(posedge clk) disable iff (rst)
        fill_ready |-> (wait_c >= (MISS_W+1)'(MISS_CYCLES)));

    assert_close_to_play_R4: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_ready && fill_last) |=> (!fill_ready && out_valid));

    assert_seg_done_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_seg_end) |=> (!out_valid && req_ready));

    assert_rom_mark_R6: assert property (@(posedge clk) disable iff (rst)
        out_from_rom |-> (out_valid && (out_uop[UOP_W-1 -: 4] == 4'hE)));

    assert_no_bubble_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_seg_end) |=> out_valid);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_uop) && $stable(out_from_rom)));
endmodule

bind tseq_top tseq_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .fill_valid   (fill_valid),
    .fill_ready   (fill_ready),
    .fill_last    (fill_last),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_uop      (out_uop),
    .out_from_rom (out_from_rom),
    .out_seg_end  (out_seg_end),
    .building     (building)
);

// File: tb/tb_tseq_top.sv
`timescale 1ns/1ps
module tb_tseq_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [11:0] req_addr;
    logic        req_ready;
    logic        fill_valid;
    logic        fill_is_tag;
    logic [15:0] fill_data;
    logic        fill_last;
    logic        fill_ready;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_uop;
    logic        out_from_rom;
    logic        out_seg_end;
    logic        building;

    int tests = 0;
    int fails = 0;

    logic [15:0] exp_uop [32];
    logic        exp_rom [32];
    int          exp_n;

    // {expected hit, stall mode, address}
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 4'd0, 12'h010},
        {1'b1, 4'd0, 12'h010},
        {1'b0, 4'd0, 12'h035},
        {1'b1, 4'd1, 12'h035},
        {1'b0, 4'd0, 12'h045},
        {1'b0, 4'd1, 12'h035},
        {1'b0, 4'd0, 12'h01F},
        {1'b1, 4'd1, 12'h01F}
    };

    always #10 clk = ~clk;

    tseq_top dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .req_ready    (req_ready),
        .fill_valid   (fill_valid),
        .fill_is_tag  (fill_is_tag),
        .fill_data    (fill_data),
        .fill_last    (fill_last),
        .fill_ready   (fill_ready),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_uop      (out_uop),
        .out_from_rom (out_from_rom),
        .out_seg_end  (out_seg_end),
        .building     (building)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int seg_len(input logic [11:0] a);
        return (int'(a) % 6) + 1;
    endfunction

    function automatic bit ent_tag(input logic [11:0] a, input int k);
        int n = seg_len(a);
        return (k == 0 && a[6]) || (k == 2 && a[4]) || (k == n - 1 && a[5]);
    endfunction

    function automatic logic [15:0] ent_data(input logic [11:0] a, input int k);
        if (ent_tag(a, k)) return 16'((int'(a) * 3 + k * 5) % 32);
        return 16'(int'(a) * 8 + k);
    endfunction

    task automatic build_expect(input logic [11:0] a);
        exp_n = 0;
        for (int k = 0; k < seg_len(a); k++) begin
            if (ent_tag(a, k)) begin
                int p = int'(ent_data(a, k));
                for (int w = 0; w < 4; w++) begin
                    exp_uop[exp_n] = 16'hE000 | 16'(p);
                    exp_rom[exp_n] = 1'b1;
                    exp_n++;
                    if ((p % 4) == 3) break;
                    p++;
                end
            end else begin
                exp_uop[exp_n] = ent_data(a, k);
                exp_rom[exp_n] = 1'b0;
                exp_n++;
            end
        end
    endtask

    task automatic run_segment(input logic [11:0] a, input int mode, input bit exp_hit);
        int cnt;
        int k;
        int bubbles;
        bit prev_stall;
        logic [15:0] prev_uop;
        bit done;
        build_expect(a);
        @(negedge clk);
        check(req_ready == 1'b1, "R5", "idle before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            check(building == 1'b0, "R2", "no build on hit", int'(building), 0);
            check(out_valid == 1'b1, "R2", "replay next cycle", int'(out_valid), 1);
        end else begin
            check(building == 1'b1, "R3", "build flag on miss", int'(building), 1);
            cnt = 0;
            while (!fill_ready && cnt < 40) begin
                cnt++;
                @(negedge clk);
            end
            check(cnt == 8, "R3", "miss delay cycles", cnt, 8);
            for (int j = 0; j < seg_len(a); j++) begin
                check(fill_ready == 1'b1 && out_valid == 1'b0, "R4", "fill accepted",
                      int'(fill_ready), 1);
                fill_valid  = 1'b1;
                fill_is_tag = ent_tag(a, j);
                fill_data   = ent_data(a, j);
                fill_last   = (j == seg_len(a) - 1) && (seg_len(a) < 6);
                @(negedge clk);
            end
            fill_valid = 1'b0;
            fill_last  = 1'b0;
            check(fill_ready == 1'b0 && building == 1'b0, "R4", "segment closed",
                  int'(fill_ready), 0);
            check(out_valid == 1'b1, "R4", "replay after close", int'(out_valid), 1);
        end
        k = 0;
        bubbles = 0;
        prev_stall = 1'b0;
        prev_uop = '0;
        done = 1'b0;
        for (int cyc = 0; cyc < 200 && !done; cyc++) begin
            out_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            if (!out_valid) bubbles++;
            if (prev_stall)
                check(out_valid && out_uop == prev_uop, "R8", "hold under stall",
                      int'(out_uop), int'(prev_uop));
            if (out_ready && out_valid) begin
                if (k < exp_n) begin
                    check(out_uop == exp_uop[k], exp_rom[k] ? "R6" : "R5", "word value",
                          int'(out_uop), int'(exp_uop[k]));
                    check(out_from_rom == exp_rom[k], "R6", "source flag",
                          int'(out_from_rom), int'(exp_rom[k]));
                end
                if (out_seg_end) begin
                    done = 1'b1;
                    check(k == exp_n - 1, "R5", "segment end position", k, exp_n - 1);
                end
                k++;
            end
            prev_stall = out_valid && !out_ready;
            prev_uop   = out_uop;
            @(negedge clk);
        end
        out_ready = 1'b1;
        check(bubbles == 0, "R7", "bubbles in replay", bubbles, 0);
        check(out_valid == 1'b0 && req_ready == 1'b1, "R5", "idle after end",
              int'(out_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_addr = '0;
        fill_valid = 1'b0;
        fill_is_tag = 1'b0;
        fill_data = '0;
        fill_last = 1'b0;
        out_ready = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0 && fill_ready == 1'b0 && building == 1'b0, "R1",
              "reset outputs low", int'({out_valid, fill_ready, building}), 0);
        check(req_ready == 1'b1, "R1", "reset idle", int'(req_ready), 1);
        rst = 1'b0;

        for (int v = 0; v < 8; v++) begin
            // R9: vector 4 evicts index 5, so vector 5 must miss
            run_segment(VEC[v][11:0], int'(VEC[v][15:12]), VEC[v][16]);
        end

        // R1: reset clears the store, so a previously stored address misses
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0 && req_ready == 1'b1, "R1", "state after second reset",
              int'(out_valid), 0);
        rst = 1'b0;
        run_segment(12'h010, 1, 1'b0);
        // R9: rebuilt segment is found again
        run_segment(12'h010, 0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule